// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A memory-mapped watchdog with a 32-bit write port. Software loads a 16-bit up-counter with 65536 − N, picks one of eight prescaler dividers and sets the enable bit. Each time the prescaler ticks, the counter advances by one. When it steps past 0xFFFF, the block asks the system reset controller for a reset and sets a sticky flag that survives that reset. Software can then read the flag to tell that the watchdog caused the restart.

A write is accepted only when the upper bits of the write data carry the unlock pattern for the addressed register. An accepted write does not update the register at once. The value is held for a short transfer window, and a read-only busy bit is shown during that window. The new value takes effect as the busy bit drops, and any write made during the window is dropped. Two active-low asynchronous resets are provided. The ordinary reset (`rst_ni`) leaves the overflow flag alone. The power-on reset (`por_ni`) clears everything, including that flag.

Top module: `wdt_keyed_top`

## Requirements
- R1: Reads (byte offsets, `rdata_o` combinational on `addr_i`) work as follows. Offset 0x0 returns the count in bits [15:0]. Offset 0x4 returns the enable bit in bit 7, the busy bit in bit 5, the overflow flag in bit 4 and the divider code in bits [2:0]. Offset 0x8 returns the 8-bit auxiliary control byte in bits [7:0]. Every other bit and every other offset reads 0.
- R2: A write to offset 0x0 is accepted only when wdata[31:16] = 0x5A5A. The count is taken from wdata[15:0]. Any other upper value is dropped.
- R3: A write to offset 0x4 or 0x8 is accepted only when wdata[31:8] = 0xA5A5A5. The register value is taken from wdata[7:0].
- R4: While enabled, the counter increments by one on each prescaler tick. While disabled, it holds its value.
- R5: Divider codes 0 to 7 give one tick every 1, 4, 16, 32, 64, 128, 1024 or 4096 clocks. The prescaler restarts from zero whenever the count or the offset-0x4 register is updated.
- R6: After an accepted write, the busy bit reads 1 for exactly 3 cycles. The written value becomes visible in the cycle the busy bit reads 0 again. Writes made while the busy bit is 1 are ignored.
- R7: A tick at count 0xFFFF wraps the counter to 0, sets the overflow flag, and counting continues.
- R8: Each wrap drives `wdt_rst_o` high for exactly 16 clock cycles, starting the cycle after the wrap edge.
- R9: The overflow flag is not cleared by `rst_ni`. It is cleared by `por_ni` or by an accepted offset-0x4 write with bit 4 = 0. Writing 1 to bit 4 does not set it.
- R10: Writes to unmapped offsets are dropped and do not start a busy window.
- R11: After `por_ni`, every register reads 0 and `wdt_rst_o` is 0. After `rst_ni` alone, everything except the overflow flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Ordinary async reset, active low; keeps overflow flag |
| por_ni | input | 1 | Power-on async reset, active low; clears everything |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 4 | Byte offset for read and write |
| wdata_i | input | 32 | Write data including unlock key |
| rdata_o | output | 32 | Read data for addr_i |
| wdt_rst_o | output | 1 | System reset request pulse |

## Verification
The hardest state to reach is the moment a wrap and a reset interact. This includes an overflow flag that must outlive an ordinary reset, and flag clearing that competes with the busy window. The stimulus loads the counter just below the wrap point, enables it, and lets it overflow. It then pulses `rst_ni` while the flag is set, and afterwards clears the flag through a keyed write. Separate runs load 0xFFFF under each divider code, so that every divider's wrap timing and reset pulse width are compared cycle by cycle against the bench model.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned MAX_DIV  = 4096;
  localparam logic [15:0] KEY_CNT  = 16'h5A5A;
  localparam logic [23:0] KEY_CTL  = 24'hA5A5A5;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTLA = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTLB = 4'h8;

  typedef enum logic [1:0] {TGT_NONE, TGT_CNT, TGT_CTLA, TGT_CTLB} tgt_e;

  function automatic int unsigned div_of(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 4;
      3'd2: return 16;
      3'd3: return 32;
      3'd4: return 64;
      3'd5: return 128;
      3'd6: return 1024;
      default: return 4096;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned PRE_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [2:0] cks_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim_tab [8];

  for (genvar g = 0; g < 8; g++) begin : g_lim
    assign lim_tab[g] = PRE_W'(div_of(3'(g)) - 1);
  end

  assign tick_o = en_i && (pre_q == lim_tab[cks_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pre_q <= '0;
    else if (!en_i || clr_i || tick_o) pre_q <= '0;
    else                               pre_q <= pre_q + 1'b1;
  end

  // R5: a divider above 1 never ticks on two adjacent cycles
  a_r5_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cks_i != 3'd0 && !clr_i) |=> !tick_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_LEN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             rst_req_o
);
  localparam int unsigned RW = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]    rst_cnt_q;

  assign wrap_o    = tick_i && (&cnt_q) && !load_i;
  assign cnt_o     = cnt_q;
  assign rst_req_o = (rst_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rst_cnt_q <= '0;
    else if (wrap_o)            rst_cnt_q <= RW'(RST_LEN);
    else if (rst_cnt_q != '0)   rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  // R4: no tick and no load leaves the count untouched
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  // R7: a wrap lands at zero
  a_r7_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  // R8: a wrap raises the reset request
  a_r8_req_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> rst_req_o);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned BUSY_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic [2:0]        cks_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              clr_o
);
  localparam int unsigned BW = $clog2(BUSY_LEN + 1);

  logic [BW-1:0]    busy_q;
  tgt_e             tgt, pend_tgt_q;
  logic [CNT_W-1:0] pend_q;
  logic             busy, accept, apply;
  logic             en_q, ovf_q;
  logic [2:0]       cks_q;
  logic [7:0]       ctlb_q;

  always_comb begin
    tgt = TGT_NONE;
    if (wr_en_i) begin
      if (addr_i == OFS_CNT && wdata_i[31:16] == KEY_CNT)       tgt = TGT_CNT;
      else if (addr_i == OFS_CTLA && wdata_i[31:8] == KEY_CTL)  tgt = TGT_CTLA;
      else if (addr_i == OFS_CTLB && wdata_i[31:8] == KEY_CTL)  tgt = TGT_CTLB;
    end
  end

  assign busy   = (busy_q != '0);
  assign accept = (tgt != TGT_NONE) && !busy;
  assign apply  = (busy_q == BW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= '0;
      pend_tgt_q <= TGT_NONE;
      pend_q     <= '0;
    end else if (accept) begin
      busy_q     <= BW'(BUSY_LEN);
      pend_tgt_q <= tgt;
      pend_q     <= wdata_i[CNT_W-1:0];
    end else if (busy) begin
      busy_q     <= busy_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cks_q  <= '0;
      ctlb_q <= '0;
    end else if (apply) begin
      if (pend_tgt_q == TGT_CTLA) begin
        en_q  <= pend_q[7];
        cks_q <= pend_q[2:0];
      end
      if (pend_tgt_q == TGT_CTLB) ctlb_q <= pend_q[7:0];
    end
  end

  // overflow flag: power-on reset only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                                         ovf_q <= 1'b0;
    else if (wrap_i)                                     ovf_q <= 1'b1;
    else if (apply && pend_tgt_q == TGT_CTLA && !pend_q[4]) ovf_q <= 1'b0;
  end

  assign en_o       = en_q;
  assign cks_o      = cks_q;
  assign load_o     = apply && (pend_tgt_q == TGT_CNT);
  assign load_val_o = pend_q;
  assign clr_o      = apply && (pend_tgt_q == TGT_CNT || pend_tgt_q == TGT_CTLA);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CNT:  rdata_o[CNT_W-1:0] = cnt_i;
      OFS_CTLA: rdata_o[7:0] = {en_q, 1'b0, busy, ovf_q, 1'b0, cks_q};
      OFS_CTLB: rdata_o[7:0] = ctlb_q;
      default:  rdata_o = '0;
    endcase
  end

  // R6: an accepted write opens the busy window
  a_r6_busy_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (busy_q == BW'(BUSY_LEN)));
  // R6: writes during the window do not restart it
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_en_i) |=> (busy_q == $past(busy_q) - 1'b1));
  // R2/R3/R10: unkeyed or unmapped write on an idle port starts nothing
  a_r10_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && tgt == TGT_NONE) |=> !busy);
  // R9: the flag only falls through a keyed clear
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!por_ni)
    (ovf_q && !(apply && pend_tgt_q == TGT_CTLA)) |=> ovf_q);
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned BUSY_LEN = 3,
  parameter int unsigned RST_LEN  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o
);
  localparam int unsigned PRE_W = $clog2(MAX_DIV);

  logic             sys_rst_n;
  logic             en, load, clr, tick, wrap;
  logic [2:0]       cks;
  logic [CNT_W-1:0] cnt, load_val;

  assign sys_rst_n = rst_ni & por_ni;

  wdt_regs #(.BUSY_LEN(BUSY_LEN)) u_regs (
    .clk_i(clk_i), .rst_ni(sys_rst_n), .por_ni(por_ni),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .cnt_i(cnt), .wrap_i(wrap), .rdata_o(rdata_o),
    .en_o(en), .cks_o(cks), .load_o(load), .load_val_o(load_val), .clr_o(clr)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(sys_rst_n), .en_i(en), .clr_i(clr),
    .cks_i(cks), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_cnt (
    .clk_i(clk_i), .rst_ni(sys_rst_n), .tick_i(tick), .load_i(load),
    .load_val_i(load_val), .cnt_o(cnt), .wrap_o(wrap), .rst_req_o(wdt_rst_o)
  );
endmodule

// File: tb/wdt_keyed_top_tb.sv
module wdt_keyed_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;

  int compared = 0, mismatched = 0;
  string cur_req = "R11";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_keyed_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  // reference model
  int divs [8] = '{1, 4, 16, 32, 64, 128, 1024, 4096};
  int m_cnt, m_en, m_cks, m_ovf, m_ctlb, m_busy, m_tgt, m_pend, m_pre, m_rst;

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n || !rst_n) begin
      if (!por_n) m_ovf = 0;
      m_cnt = 0; m_en = 0; m_cks = 0; m_ctlb = 0; m_busy = 0;
      m_tgt = 0; m_pend = 0; m_pre = 0; m_rst = 0;
    end else begin
      int t;
      bit tick, app, wrp;
      tick = (m_en != 0) && (m_pre == divs[m_cks] - 1);
      app  = (m_busy == 1);
      wrp  = tick && m_cnt == 65535 && !(app && m_tgt == 1);
      t = 0;
      if (wr_en) begin
        if (addr == 4'h0 && wdata[31:16] == 16'h5A5A) t = 1;
        else if (addr == 4'h4 && wdata[31:8] == 24'hA5A5A5) t = 2;
        else if (addr == 4'h8 && wdata[31:8] == 24'hA5A5A5) t = 3;
      end
      if (wrp) m_rst = 16; else if (m_rst > 0) m_rst--;
      if (wrp) m_ovf = 1;
      else if (app && m_tgt == 2 && ((m_pend >> 4) & 1) == 0) m_ovf = 0;
      if (m_en == 0 || (app && (m_tgt == 1 || m_tgt == 2)) || tick) m_pre = 0;
      else m_pre++;
      if (app && m_tgt == 1) m_cnt = m_pend;
      else if (tick) m_cnt = (m_cnt + 1) % 65536;
      if (app && m_tgt == 2) begin m_en = (m_pend >> 7) & 1; m_cks = m_pend & 7; end
      if (app && m_tgt == 3) m_ctlb = m_pend & 255;
      if (t != 0 && m_busy == 0) begin m_busy = 3; m_tgt = t; m_pend = wdata[15:0]; end
      else if (m_busy > 0) m_busy--;
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return 32'(m_cnt);
      4'h4: return 32'((m_en << 7) | ((m_busy != 0) << 5) | (m_ovf << 4) | m_cks);
      4'h8: return 32'(m_ctlb);
      default: return 32'h0;
    endcase
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (rdata !== m_read(addr) || wdt_rst !== (m_rst != 0)) begin
        mismatched++;
        $display("FAIL %s addr=%h rdata=%h exp=%h rst=%b exp=%b", cur_req, addr,
                 rdata, m_read(addr), wdt_rst, m_rst != 0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      addr = 4'(4 * (i % 4));
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic spot(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(posedge clk); #1; addr = a;
    @(negedge clk);
    compared++;
    if (rdata !== exp) begin
      mismatched++;
      $display("FAIL %s spot addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    // R11 reset state
    spot("R11", 4'h0, 32'h0);
    spot("R11", 4'h4, 32'h0);
    spot("R1", 4'hC, 32'h0);

    cur_req = "R2"; // wrong key on counter
    wr(4'h0, 32'h12341234); idle(5);
    spot("R2", 4'h0, 32'h0);

    cur_req = "R3"; // wrong and right key on aux register
    wr(4'h8, 32'hA5A5A400 | 32'h3C); idle(5);
    spot("R3", 4'h8, 32'h0);
    wr(4'h8, 32'hA5A5A53C); idle(5);
    spot("R3", 4'h8, 32'h3C);

    cur_req = "R10"; // unmapped offset
    wr(4'hC, 32'hA5A5A5FF);
    spot("R10", 4'h4, 32'h0);

    cur_req = "R6"; // busy window and writes inside it
    wr(4'h0, 32'h5A5AFFF0);
    spot("R6", 4'h4, 32'h20);
    wr(4'h0, 32'h5A5A0001); idle(4);
    spot("R6", 4'h0, 32'h0000FFF0);

    cur_req = "R7"; // R4 counting then R8 reset pulse
    wr(4'h4, 32'hA5A5A580); idle(40);
    spot("R7", 4'h4, 32'h90);

    cur_req = "R9"; // ordinary reset keeps the flag
    @(posedge clk); #1; rst_n = 1'b0;
    idle(2);
    @(posedge clk); #1; rst_n = 1'b1;
    spot("R9", 4'h4, 32'h10);
    spot("R11", 4'h0, 32'h0);
    wr(4'h4, 32'hA5A5A510); idle(5);
    spot("R9", 4'h4, 32'h10);
    wr(4'h4, 32'hA5A5A500); idle(5);
    spot("R9", 4'h4, 32'h00);

    cur_req = "R5"; // every divider from 0xFFFF
    for (int c = 0; c < 8; c++) begin
      wr(4'h4, 32'hA5A5A500); idle(4);
      wr(4'h0, 32'h5A5AFFFF); idle(4);
      wr(4'h4, 32'hA5A5A580 | 32'(c)); idle(divs[c] + 30);
    end

    cur_req = "R4"; // stop holds count
    wr(4'h4, 32'hA5A5A500); idle(20);

    cur_req = "R11"; // power-on reset clears the flag
    @(posedge clk); #1; por_n = 1'b0;
    idle(2);
    @(posedge clk); #1; por_n = 1'b1;
    spot("R11", 4'h4, 32'h0);
    idle(5);
    finish_run();
  end
endmodule